// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Acknowledge Engine

This block is the delivery end of an interrupt controller for a single processor. A source unit sends it one-cycle raise strobes, along with the live priority, vector and sense (edge or level) of each source. The block holds two bit-sets indexed by source: the raised set and the in-service set. It also holds a 4-bit task priority and one activity bit per source. It drives the processor's interrupt request line.

The processor reaches the block through a small register port. Address 0 is the task priority, read and write. A read of address 1 is the acknowledge. A write to address 2 is the end-of-interrupt. Address 3 is the spurious vector, read and write.

Read data is combinational. It is valid in the same cycle as `reg_rd`, and any side effects of the read take place at the next rising edge. Each set is scanned by index in ascending order for its highest priority, and a lower index wins a tie.

Top module: `prio_ack_engine`

## Requirements
- R1: After reset the task priority is 0xF, the raised and in-service sets are empty, every activity bit is 0, `irq_o` is low and the spurious vector is 0xFF.
- R2: A raise strobe is ignored when the source priority is less than or equal to the task priority, or when the source's raised bit is already set. An ignored strobe leaves the activity bit and `irq_o` unchanged.
- R3: An accepted raise sets the source's raised and activity bits. It asserts `irq_o` only when its priority is strictly greater than the highest priority in the raised set before the raise. An empty set counts as priority 0.
- R4: The acknowledge winner is the raised source with the highest priority. Among sources of equal priority, the lowest index wins.
- R5: An acknowledge read with an empty raised set returns the spurious vector and changes no state.
- R6: When the raised set is not empty but the winner's activity bit is clear, or its priority no longer exceeds the task priority, the acknowledge returns the spurious vector. In that case the block clears the winner's activity and raised bits.
- R7: A valid acknowledge returns the winner's vector, clears its raised bit and sets its in-service bit. It clears the activity bit only for an edge source (sense 0) and keeps it for a level source (sense 1). Any acknowledge that finds a non-empty raised set drops `irq_o` in the next cycle, unless a qualifying raise arrives in the same cycle.
- R8: An end-of-interrupt write clears the highest-priority in-service bit. It asserts `irq_o` when the best raised priority is strictly greater than the highest priority left in service, where an empty in-service set counts as 0.
- R9: A task-priority write keeps only the low 4 bits of the write data. A write to address 3 replaces the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | NSRC | Per-source raise strobe |
| deact_i | input | NSRC | Per-source activity clear (level source released) |
| src_prio_i | input | NSRC*PW | Priority of each source, packed |
| src_vec_i | input | NSRC*VW | Vector of each source, packed |
| src_level_i | input | NSRC | Sense of each source, 1 = level |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 task prio, 1 ack, 2 EOI, 3 spurious) |
| reg_wdata | input | VW | Write data |
| reg_rdata | output | VW | Read data, combinational |
| active_o | output | NSRC | Activity bits |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that a read and a write never occur in the same cycle, and that a raise strobe does not arrive in the cycle of an acknowledge or end-of-interrupt it would race with. Some checks also assume that source priorities stay stable while a register access is in progress. The stimulus drives one operation per two-cycle slot and changes priorities only between slots, so these assumptions always hold. The sequence covers ties, stale winners after the task priority rises, a level source whose activity is dropped before acknowledge, and end-of-interrupt both with and without a re-raise.

// File: rtl/prio_ack_engine.sv
module prio_ack_engine #(
  parameter int NSRC = 8,
  parameter int PW   = 5,
  parameter int VW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   raise_i,
  input  logic [NSRC-1:0]   deact_i,
  input  logic [NSRC*PW-1:0] src_prio_i,
  input  logic [NSRC*VW-1:0] src_vec_i,
  input  logic [NSRC-1:0]   src_level_i,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [VW-1:0]     reg_wdata,
  output logic [VW-1:0]     reg_rdata,
  output logic [NSRC-1:0]   active_o,
  output logic              irq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SW = 1 + IW + PW;

  logic [NSRC-1:0] raised_q, inserv_q, active_q;
  logic [3:0]      tp_q;
  logic [VW-1:0]   spur_q;
  logic            irq_q;

  function automatic logic [SW-1:0] pick(input logic [NSRC-1:0] m,
                                         input logic [NSRC*PW-1:0] pr);
    logic          any;
    logic [IW-1:0] idx;
    logic [PW-1:0] best;
    any = 1'b0; idx = '0; best = '0;
    for (int i = 0; i < NSRC; i++)
      if (m[i] && (!any || pr[i*PW +: PW] > best)) begin
        any = 1'b1; idx = IW'(i); best = pr[i*PW +: PW];
      end
    return {any, idx, best};
  endfunction

  logic          r_any, s_any, s2_any;
  logic [IW-1:0] r_idx, s_idx, s2_idx;
  logic [PW-1:0] r_pri, s_pri, s2_pri;
  logic [PW-1:0] tp_ext;

  assign {r_any, r_idx, r_pri} = pick(raised_q, src_prio_i);
  assign {s_any, s_idx, s_pri} = pick(inserv_q, src_prio_i);
  assign {s2_any, s2_idx, s2_pri} =
    pick(inserv_q & ~(s_any ? (NSRC'(1) << s_idx) : '0), src_prio_i);
  assign tp_ext = PW'(tp_q);

  logic ack, eoi, w_ok;
  assign ack  = reg_rd && reg_addr == 2'd1;
  assign eoi  = reg_wr && reg_addr == 2'd2;
  assign w_ok = r_any && active_q[r_idx] && r_pri > tp_ext;

  logic [NSRC-1:0] accept;
  logic            hi_raise;
  always_comb begin
    hi_raise = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      accept[i] = raise_i[i] && !raised_q[i] && src_prio_i[i*PW +: PW] > tp_ext;
      if (accept[i] && src_prio_i[i*PW +: PW] > r_pri) hi_raise = 1'b1;
    end
  end

  logic [NSRC-1:0] w_hot, s_hot, raised_n, inserv_n, active_n;
  logic            irq_n;
  always_comb begin
    w_hot    = NSRC'(1) << r_idx;
    s_hot    = NSRC'(1) << s_idx;
    raised_n = raised_q;
    inserv_n = inserv_q;
    active_n = active_q & ~deact_i;
    irq_n    = irq_q;
    if (ack && r_any) begin
      raised_n = raised_n & ~w_hot;
      irq_n    = 1'b0;
      if (w_ok) inserv_n = inserv_n | w_hot;
      if (!w_ok || !src_level_i[r_idx]) active_n = active_n & ~w_hot;
    end
    if (eoi) begin
      if (s_any) inserv_n = inserv_n & ~s_hot;
      if (r_pri > s2_pri) irq_n = 1'b1;
    end
    raised_n = raised_n | accept;
    active_n = active_n | accept;
    if (hi_raise) irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q <= '0;
      inserv_q <= '0;
      active_q <= '0;
      tp_q     <= 4'hF;
      spur_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      raised_q <= raised_n;
      inserv_q <= inserv_n;
      active_q <= active_n;
      irq_q    <= irq_n;
      if (reg_wr && reg_addr == 2'd0) tp_q   <= reg_wdata[3:0];
      if (reg_wr && reg_addr == 2'd3) spur_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = VW'(tp_q);
      2'd1:    reg_rdata = w_ok ? src_vec_i[r_idx*VW +: VW] : spur_q;
      2'd3:    reg_rdata = spur_q;
      default: reg_rdata = '0;
    endcase
  end

  assign active_o = active_q;
  assign irq_o    = irq_q;

  assert_empty_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !r_any) |-> reg_rdata == spur_q);

  assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && w_ok && !reg_wr) |=> inserv_q[$past(r_idx)] && !raised_q[$past(r_idx)]);

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && r_any && raise_i == '0 && !reg_wr) |=> !irq_o);

  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && s_any && !reg_rd) |=>
      $countones(inserv_q) == $countones($past(inserv_q)) - 1);

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && !reg_wr && raise_i == '0) |=> $stable(raised_q) && $stable(inserv_q));
endmodule

// File: tb/prio_ack_engine_test.sv
module prio_ack_engine_test;
  localparam int NSRC = 8, PW = 5, VW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] raise_i = '0, deact_i = '0, src_level_i = '0;
  logic [NSRC*PW-1:0] src_prio_i = '0;
  logic [NSRC*VW-1:0] src_vec_i;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [VW-1:0] reg_wdata = '0, reg_rdata;
  logic [NSRC-1:0] active_o;
  logic irq_o;

  int checks = 0, errors = 0;
  logic [VW-1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  prio_ack_engine #(.NSRC(NSRC), .PW(PW), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .deact_i(deact_i),
    .src_prio_i(src_prio_i), .src_vec_i(src_vec_i), .src_level_i(src_level_i),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .active_o(active_o), .irq_o(irq_o));

  initial for (int i = 0; i < NSRC; i++) src_vec_i[i*VW +: VW] = VW'(8'h40 + i);

  always begin
    @(negedge clk); #2;
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL unexpected read actual %h expected none", reg_rdata);
      end else begin
        automatic logic [VW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++; $display("FAIL %s read actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [VW-1:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [VW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic raise(input int s);
    raise_i = NSRC'(1) << s;
    @(negedge clk); raise_i = '0;
    @(negedge clk);
  endtask

  task automatic deact(input int s);
    deact_i = NSRC'(1) << s;
    @(negedge clk); deact_i = '0;
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++; $display("FAIL %s actual %b expected %b", t, act, e);
    end
  endtask

  task automatic setp(input int s, input int p);
    src_prio_i[s*PW +: PW] = PW'(p);
  endtask

  initial begin
    #4000000;
    errors++; $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o, 1'b0, "R1 irq after reset");
    chk(active_o == '0, 1'b1, "R1 activity empty");
    rd(2'd0, 8'h0F, "R1 task prio");
    rd(2'd3, 8'hFF, "R1 spurious");
    rd(2'd1, 8'hFF, "R5 empty ack");
    wr(2'd0, 8'h13);
    rd(2'd0, 8'h03, "R9 task prio low bits");
    wr(2'd0, 8'h02);
    setp(0, 2); setp(1, 5); setp(2, 5); setp(3, 9);
    setp(4, 1); setp(5, 3); setp(6, 3); setp(7, 3);
    src_level_i = 8'b0010_0000;
    raise(0);
    chk(irq_o, 1'b0, "R2 low prio raise irq");
    chk(active_o[0], 1'b0, "R2 low prio raise activity");
    raise(1);
    chk(irq_o, 1'b1, "R3 raise irq");
    chk(active_o[1], 1'b1, "R3 raise activity");
    raise(2);
    rd(2'd1, 8'h41, "R4 tie lowest index");
    chk(irq_o, 1'b0, "R7 irq drops");
    chk(active_o[1], 1'b0, "R7 edge activity cleared");
    raise(3);
    chk(irq_o, 1'b1, "R3 higher raise irq");
    rd(2'd1, 8'h43, "R4 highest wins");
    raise(1);
    chk(irq_o, 1'b0, "R3 equal priority no irq");
    wr(2'd2, 8'h00);
    chk(irq_o, 1'b0, "R8 no reraise when not outranking");
    wr(2'd2, 8'h00);
    chk(irq_o, 1'b1, "R8 reraise after EOI");
    rd(2'd1, 8'h41, "R4 tie after EOI");
    wr(2'd0, 8'h06);
    rd(2'd1, 8'hFF, "R6 stale priority spurious");
    chk(active_o[2], 1'b0, "R6 activity cleared");
    rd(2'd1, 8'hFF, "R6 raised bit cleared");
    wr(2'd3, 8'h3C);
    rd(2'd1, 8'h3C, "R9 new spurious on empty ack");
    wr(2'd0, 8'h02);
    raise(5);
    chk(irq_o, 1'b1, "R3 level raise irq");
    rd(2'd1, 8'h45, "R7 level vector");
    chk(active_o[5], 1'b1, "R7 level activity kept");
    deact(5);
    raise(5);
    chk(active_o[5], 1'b1, "R3 level re-raise activity");
    deact(5);
    rd(2'd1, 8'h3C, "R6 inactive winner spurious");
    chk(irq_o, 1'b0, "R7 irq low after spurious ack");
    raise(3);
    raise(3);
    rd(2'd1, 8'h43, "R2 duplicate raise single entry");
    rd(2'd1, 8'h3C, "R2 duplicate raise ignored");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule